// File: doc/BRIEF.md
# Float to Unsigned Integer Converter (Ceiling Rounding)

This block turns one IEEE 754 binary floating-point operand into an unsigned integer, always rounding toward positive infinity. The source may be half, single or double precision, picked by a 2-bit type code, and a width bit picks a 32-bit or a 64-bit integer result. The operand is taken on a clock edge where `inValid` is high, and the result, with its status, is registered and shown one cycle later together with `outValid`.

Two exceptions are detected: invalid operation (NaN, a value that cannot be represented after rounding, or any value at or below -1) and inexact (fraction bits were dropped). Each exception has its own trap enable bit. With the bit clear the exception shows on its status flag. With the bit set the flag stays low and a trap request is raised instead. A source type code with no defined format is reported on its own illegal-operation output and produces no conversion.

Top module: `fp2uint_ceil`

## Requirements
- R1: `opType` selects the source format: 2'b00 single (bits 31:0 of `operand`), 2'b01 double (bits 63:0), 2'b11 half (bits 15:0). An operand taken while `inValid` is high gives its result on the next rising edge, with `outValid` high for that one cycle.
- R2: A positive finite value whose fraction is nonzero gives its integer part plus one and raises inexact. An exact integer gives itself with no flag.
- R3: With `resWide`=0 the result is limited to 32 bits and bits 63:32 of `result` are zero. With `resWide`=1 the full 64 bits are used.
- R4: A positive value whose rounded result is above the largest value of the selected width, and +infinity, give all ones in the selected width (upper half zero when narrow), raise invalid, and do not raise inexact.
- R5: A NaN of any kind gives result 0 and raises invalid.
- R6: A negative value strictly between -1.0 and 0 gives 0 and raises only inexact. A value of -1.0 or lower, including -infinity, gives 0 and raises only invalid. Zero of either sign gives 0 with no flag.
- R7: A positive subnormal input gives 1 and raises inexact.
- R8: `opType`=2'b10 raises `illegalOp` for that result, with `result` 0 and all flags and `trapReq` low.
- R9: `trapEnable` bit 0 belongs to invalid and bit 1 to inexact. An exception whose bit is set drives `trapReq` high and leaves its flag low. An exception whose bit is clear drives its flag high and does not add to `trapReq`.
- R10: During reset and after it, all outputs are zero. `outValid` is low in any cycle that follows an edge where `inValid` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand present this cycle |
| opType | input | 2 | Source format code |
| resWide | input | 1 | 0: 32-bit result, 1: 64-bit result |
| operand | input | 64 | Floating-point source bits, right aligned |
| trapEnable | input | 2 | Trap enables: bit 0 invalid, bit 1 inexact |
| outValid | output | 1 | Result registered this cycle |
| result | output | 64 | Unsigned integer result |
| flagInvalid | output | 1 | Invalid operation, not trapped |
| flagInexact | output | 1 | Inexact, not trapped |
| trapReq | output | 1 | An enabled exception occurred |
| illegalOp | output | 1 | Undefined source type code |

## Verification
Every half-precision bit pattern is converted in the narrow mode, and a strided subset in the wide mode. Together these cover subnormals, both zeros, both infinities, all NaN payloads and every exponent of that format. Single and double sweeps visit each exponent near and past the integer range. They use mantissas with only the lowest bit set, only the top bit set, all bits set and mixed bits, so a truncated result, a wrong carry into the integer part, and a wrong saturation limit per width each show up as a different mismatch. The trap enables rotate through the sweeps, so the flag-versus-trap routing is checked against every class of exception. Targeted cases cover -1.0 against -0.5, values just over 2^32 in the narrow mode, and the undefined type code.

// File: rtl/fpcvt_pkg.sv
package fpcvt_pkg;

  localparam int OPER_W   = 64;  // widest source operand
  localparam int INT_W    = 64;  // widest integer result
  localparam int NARROW_W = 32;  // narrow integer result
  localparam int CFRAC_W  = 52;  // common aligned fraction width
  localparam int CEXP_W   = 13;  // signed unbiased exponent width
  localparam int N_FMT    = 3;

  typedef enum logic [1:0] {
    FMT_SINGLE = 2'b00,
    FMT_DOUBLE = 2'b01,
    FMT_BAD    = 2'b10,
    FMT_HALF   = 2'b11
  } srcFmt_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;
    logic       illegal;
    logic       wide;
    srcFmt_e    fmt;
    logic [1:0] trapMask;   // [0] invalid, [1] inexact
  } cvtCtrl_t;

  // format slot g: 0 half, 1 single, 2 double
  function automatic int fmtExpW(input int g);
    case (g)
      0:       return 5;
      1:       return 8;
      default: return 11;
    endcase
  endfunction

  function automatic int fmtFracW(input int g);
    case (g)
      0:       return 10;
      1:       return 23;
      default: return 52;
    endcase
  endfunction

endpackage

// File: rtl/fpcvt_field.sv
module fpcvt_field #(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter int CFRACW  = 52,
  parameter int EXPOUTW = 13
) (
  input  logic [EXP_W+FRAC_W:0]      bits,
  output logic                       sign,
  output logic                       expMax,
  output logic                       expZero,
  output logic                       fracZero,
  output logic signed [EXPOUTW-1:0]  expUnb,
  output logic [CFRACW-1:0]          fracAl
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int TOP  = EXP_W + FRAC_W;

  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] fracField;

  assign sign      = bits[TOP];
  assign expField  = bits[TOP-1:FRAC_W];
  assign fracField = bits[FRAC_W-1:0];
  assign expMax    = &expField;
  assign expZero   = ~|expField;
  assign fracZero  = ~|fracField;
  assign expUnb    = $signed(EXPOUTW'(expField)) - $signed(EXPOUTW'(BIAS));
  assign fracAl    = CFRACW'(fracField) << (CFRACW - FRAC_W);

endmodule

// File: rtl/fpcvt_ctrl.sv
module fpcvt_ctrl
  import fpcvt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] opType,
  input  logic       resWide,
  input  logic [1:0] trapEnable,
  output cvtCtrl_t   ctl,
  output logic       outValid,
  output logic       illegalOp
);
  srcFmt_e fmtCode;
  logic    isBad;

  assign fmtCode = srcFmt_e'(opType);
  assign isBad   = (fmtCode == FMT_BAD);

  always_comb begin
    ctl          = '0;
    ctl.load     = inValid & ~isBad;
    ctl.illegal  = inValid & isBad;
    ctl.wide     = resWide;
    ctl.fmt      = fmtCode;
    ctl.trapMask = trapEnable;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      illegalOp <= 1'b0;
    end else begin
      outValid  <= inValid;
      illegalOp <= inValid & isBad;
    end
  end

endmodule

// File: rtl/fpcvt_datapath.sv
module fpcvt_datapath
  import fpcvt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cvtCtrl_t          ctl,
  input  logic [OPER_W-1:0] operand,
  output logic [INT_W-1:0]  result,
  output logic              flagInvalid,
  output logic              flagInexact,
  output logic              trapReq
);
  localparam int SHIFT_W = 2 * INT_W;
  localparam int SIG_W   = CFRAC_W + 1;
  localparam int SHAMT_W = $clog2(INT_W);

  // ---------------- unpack, one extractor per format ----------------
  logic [N_FMT-1:0]          sgnV, expMaxV, expZeroV, fracZeroV;
  logic signed [CEXP_W-1:0]  expV  [N_FMT];
  logic [CFRAC_W-1:0]        fracV [N_FMT];

  for (genvar g = 0; g < N_FMT; g++) begin : gFmt
    localparam int EW = fmtExpW(g);
    localparam int FW = fmtFracW(g);
    fpcvt_field #(.EXP_W(EW), .FRAC_W(FW), .CFRACW(CFRAC_W), .EXPOUTW(CEXP_W)) uField (
      .bits    (operand[EW+FW:0]),
      .sign    (sgnV[g]),
      .expMax  (expMaxV[g]),
      .expZero (expZeroV[g]),
      .fracZero(fracZeroV[g]),
      .expUnb  (expV[g]),
      .fracAl  (fracV[g])
    );
  end

  int unsigned sel;
  always_comb begin
    case (ctl.fmt)
      FMT_HALF:   sel = 0;
      FMT_SINGLE: sel = 1;
      default:    sel = 2;
    endcase
  end

  logic                      sgn, isNan, isInf, isZero, isSub;
  logic signed [CEXP_W-1:0]  expUnb;
  logic [CFRAC_W-1:0]        frac;

  assign sgn    = sgnV[sel];
  assign isNan  = expMaxV[sel] & ~fracZeroV[sel];
  assign isInf  = expMaxV[sel] &  fracZeroV[sel];
  assign isZero = expZeroV[sel] & fracZeroV[sel];
  assign isSub  = expZeroV[sel] & ~fracZeroV[sel];
  assign expUnb = expV[sel];
  assign frac   = fracV[sel];

  // ---------------- integer part and ceiling ----------------
  logic              belowOne, aboveRange;
  logic [SHIFT_W-1:0] shifted;
  logic [INT_W-1:0]  intPart;
  logic              fracNz;
  logic [INT_W:0]    rounded, maxVal;
  logic [SHAMT_W-1:0] shamt;

  assign belowOne   = isSub | (expUnb < 0);
  assign aboveRange = (expUnb >= $signed(CEXP_W'(INT_W)));
  assign shamt      = expUnb[SHAMT_W-1:0];
  assign shifted    = SHIFT_W'({1'b1, frac}) << shamt;
  assign intPart    = shifted[CFRAC_W +: INT_W];
  assign fracNz     = |shifted[CFRAC_W-1:0];
  assign rounded    = {1'b0, intPart} + (INT_W+1)'(fracNz);
  assign maxVal     = ctl.wide ? {1'b0, {INT_W{1'b1}}}
                               : (INT_W+1)'({NARROW_W{1'b1}});

  logic [INT_W-1:0] convVal;
  logic             excInv, excInx;

  always_comb begin
    convVal = '0;
    excInv  = 1'b0;
    excInx  = 1'b0;
    if (isNan) begin
      excInv = 1'b1;
    end else if (isInf) begin
      excInv  = 1'b1;
      convVal = sgn ? '0 : maxVal[INT_W-1:0];
    end else if (isZero) begin
      convVal = '0;
    end else if (sgn) begin
      if (belowOne) excInx = 1'b1;   // ceiling of (-1,0) is zero
      else          excInv = 1'b1;
    end else if (belowOne) begin
      convVal = INT_W'(1);
      excInx  = 1'b1;
    end else if (aboveRange || (rounded > maxVal)) begin
      convVal = maxVal[INT_W-1:0];
      excInv  = 1'b1;
    end else begin
      convVal = rounded[INT_W-1:0];
      excInx  = fracNz;
    end
  end

  // ---------------- exception routing and output register ----------------
  logic trapInv, trapInx;
  assign trapInv = excInv & ctl.trapMask[0];
  assign trapInx = excInx & ctl.trapMask[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result      <= '0;
      flagInvalid <= 1'b0;
      flagInexact <= 1'b0;
      trapReq     <= 1'b0;
    end else if (ctl.load) begin
      result      <= convVal;
      flagInvalid <= excInv & ~trapInv;
      flagInexact <= excInx & ~trapInx;
      trapReq     <= trapInv | trapInx;
    end else if (ctl.illegal) begin
      result      <= '0;
      flagInvalid <= 1'b0;
      flagInexact <= 1'b0;
      trapReq     <= 1'b0;
    end
  end

endmodule

// File: rtl/fp2uint_ceil.sv
module fp2uint_ceil
  import fpcvt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [1:0]  opType,
  input  logic        resWide,
  input  logic [63:0] operand,
  input  logic [1:0]  trapEnable,
  output logic        outValid,
  output logic [63:0] result,
  output logic        flagInvalid,
  output logic        flagInexact,
  output logic        trapReq,
  output logic        illegalOp
);
  cvtCtrl_t ctl;

  fpcvt_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .opType    (opType),
    .resWide   (resWide),
    .trapEnable(trapEnable),
    .ctl       (ctl),
    .outValid  (outValid),
    .illegalOp (illegalOp)
  );

  fpcvt_datapath uData (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .operand    (operand),
    .result     (result),
    .flagInvalid(flagInvalid),
    .flagInexact(flagInexact),
    .trapReq    (trapReq)
  );

endmodule

// File: rtl/fpcvt_checker.sv
module fpcvt_checker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [1:0]  opType,
  input logic        resWide,
  input logic [63:0] operand,
  input logic [1:0]  trapEnable,
  input logic        outValid,
  input logic [63:0] result,
  input logic        flagInvalid,
  input logic        flagInexact,
  input logic        trapReq,
  input logic        illegalOp
);

  // R1 / R10: valid follows the input strobe by one edge
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r10_idle_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R3: narrow results never use the upper half
  a_r3_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !resWide) |=> (result[63:32] == 32'h0));

  // R4/R6: a result never raises both flags at once
  a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !(flagInvalid && flagInexact));

  // R5: a double NaN converts to zero
  a_r5_nan_zero: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opType == 2'b01 && (&operand[62:52]) && (|operand[51:0]))
      |=> (result == 64'h0));

  // R8: undefined type code is quiet apart from illegalOp
  a_r8_illegal_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opType == 2'b10) |=>
      (illegalOp && result == 64'h0 && !flagInvalid && !flagInexact && !trapReq));

  // R9: a trapped exception never shows on its flag
  a_r9_trap_masks_invalid: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && trapEnable[0]) |=> !flagInvalid);
  a_r9_trap_masks_inexact: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && trapEnable[1]) |=> !flagInexact);

endmodule

bind fp2uint_ceil fpcvt_checker uChk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .opType     (opType),
  .resWide    (resWide),
  .operand    (operand),
  .trapEnable (trapEnable),
  .outValid   (outValid),
  .result     (result),
  .flagInvalid(flagInvalid),
  .flagInexact(flagInexact),
  .trapReq    (trapReq),
  .illegalOp  (illegalOp)
);

// File: tb/sim_fp2uint_ceil.sv
module sim_fp2uint_ceil;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  opType = 2'b00;
  logic        resWide = 1'b0;
  logic [63:0] operand = '0;
  logic [1:0]  trapEnable = 2'b00;
  logic        outValid;
  logic [63:0] result;
  logic        flagInvalid, flagInexact, trapReq, illegalOp;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fp2uint_ceil u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opType(opType),
    .resWide(resWide), .operand(operand), .trapEnable(trapEnable),
    .outValid(outValid), .result(result), .flagInvalid(flagInvalid),
    .flagInexact(flagInexact), .trapReq(trapReq), .illegalOp(illegalOp)
  );

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete (actual hung, expected done)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- reference conversion ----------------
  task automatic refConv(input logic [1:0] t, input logic w, input logic [63:0] op,
                         output logic [63:0] r, output logic inv, output logic inx,
                         output string tag);
    int ew, fw, bias, e;
    logic s;
    logic [63:0] f;
    real mag, rem;
    logic [63:0] fl;
    logic [64:0] up, mx;
    bit fr;
    case (t)
      2'b11:   begin ew = 5;  fw = 10; end
      2'b00:   begin ew = 8;  fw = 23; end
      default: begin ew = 11; fw = 52; end
    endcase
    bias = (1 << (ew - 1)) - 1;
    s = op[ew + fw];
    e = int'((op >> fw) & ((64'd1 << ew) - 1));
    f = op & ((64'd1 << fw) - 1);
    mx = w ? {1'b0, {64{1'b1}}} : 65'h0_FFFF_FFFF;
    r = '0; inv = 1'b0; inx = 1'b0;
    tag = w ? "R3" : "R1";
    if (e == (1 << ew) - 1) begin
      inv = 1'b1;
      if (f != 0) tag = "R5";
      else begin tag = s ? "R6" : "R4"; if (!s) r = mx[63:0]; end
    end else if (e == 0 && f == 0) begin
      tag = "R6";
    end else if (e == 0) begin
      tag = "R7";
      inx = 1'b1;
      if (!s) r = 64'd1;
    end else begin
      mag = (1.0 + real'(f) / (2.0 ** fw)) * (2.0 ** (e - bias));
      if (s) begin
        tag = "R6";
        if (mag < 1.0) inx = 1'b1; else inv = 1'b1;
      end else if (mag >= 2.0 ** 64) begin
        tag = "R4"; inv = 1'b1; r = mx[63:0];
      end else begin
        rem = mag; fl = '0;
        for (int i = 63; i >= 0; i--) begin
          if (rem >= 2.0 ** i) begin rem = rem - 2.0 ** i; fl[i] = 1'b1; end
        end
        fr = (rem > 0.0);
        up = {1'b0, fl} + 65'(fr);
        if (up > mx) begin tag = "R4"; inv = 1'b1; r = mx[63:0]; end
        else begin r = up[63:0]; inx = fr; if (fr) tag = "R2"; end
      end
    end
  endtask

  // drives at a falling edge, compares at the next falling edge
  task automatic doOp(input logic [1:0] t, input logic w, input logic [63:0] op,
                      input logic [1:0] te);
    logic [63:0] er;
    logic ei, ex, eInv, eInx, eTrap, eIll;
    string tag;
    if (t == 2'b10) begin
      er = '0; ei = 0; ex = 0; tag = "R8";
    end else refConv(t, w, op, er, ei, ex, tag);
    eIll  = (t == 2'b10);
    eInv  = ei & ~te[0];
    eInx  = ex & ~te[1];
    eTrap = (ei & te[0]) | (ex & te[1]);
    if (te != 2'b00 && (ei || ex)) tag = {tag, "/R9"};
    opType = t; resWide = w; operand = op; trapEnable = te; inValid = 1'b1;
    @(negedge clk);
    checks++;
    if (!outValid || result !== er || flagInvalid !== eInv || flagInexact !== eInx ||
        trapReq !== eTrap || illegalOp !== eIll) begin
      errors++;
      if (errors < 20)
        $display("FAIL %s type=%b wide=%b op=%h te=%b: actual v=%b r=%h inv=%b inx=%b trap=%b ill=%b expected v=1 r=%h inv=%b inx=%b trap=%b ill=%b",
                 tag, t, w, op, te, outValid, result, flagInvalid, flagInexact, trapReq,
                 illegalOp, er, eInv, eInx, eTrap, eIll);
    end
  endtask

  function automatic logic [63:0] mantPat(input int k, input int fw);
    logic [63:0] ones;
    ones = (64'd1 << fw) - 1;
    case (k)
      0: return 64'd0;
      1: return 64'd1;
      2: return ones;
      3: return 64'd1 << (fw - 1);
      4: return 64'h5555_5555_5555_5555 & ones;
      5: return ones >> 1;
      6: return (64'd1 << (fw - 1)) | 64'd1;
      default: return 64'hA5A5_A5A5_A5A5_A5A5 & ones;
    endcase
  endfunction

  initial begin
    // R10: reset state
    #2;
    checks++;
    if (outValid !== 0 || result !== 0 || flagInvalid !== 0 || flagInexact !== 0 ||
        trapReq !== 0 || illegalOp !== 0) begin
      errors++;
      $display("FAIL R10 reset: actual v=%b r=%h expected all zero", outValid, result);
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (outValid !== 0 || result !== 0) begin
      errors++;
      $display("FAIL R10 idle after reset: actual v=%b r=%h expected v=0 r=0", outValid, result);
    end

    // targeted corner cases
    doOp(2'b11, 1'b0, 64'h3E00, 2'b00);                // R2 half 1.5 -> 2
    doOp(2'b11, 1'b0, 64'h4000, 2'b00);                // R2 half 2.0 exact
    doOp(2'b00, 1'b0, 64'h4F80_0000, 2'b00);           // R4 single 2^32 narrow
    doOp(2'b00, 1'b1, 64'h4F80_0000, 2'b00);           // R3 single 2^32 wide
    doOp(2'b01, 1'b0, 64'h41EF_FFFF_FFF0_0000, 2'b00); // R2/R4 2^32-0.5 narrow
    doOp(2'b01, 1'b0, 64'hBFF0_0000_0000_0000, 2'b00); // R6 -1.0
    doOp(2'b01, 1'b0, 64'hBFE0_0000_0000_0000, 2'b00); // R6 -0.5
    doOp(2'b01, 1'b1, 64'h7FF8_0000_0000_0001, 2'b00); // R5 NaN
    doOp(2'b00, 1'b1, 64'h0000_0001, 2'b00);           // R7 subnormal
    doOp(2'b10, 1'b1, 64'h3F80_0000, 2'b11);           // R8 undefined type
    doOp(2'b00, 1'b0, 64'h3FC0_0000, 2'b10);           // R9 inexact trapped
    doOp(2'b00, 1'b0, 64'h7F80_0000, 2'b01);           // R9 invalid trapped
    doOp(2'b00, 1'b0, 64'h7F80_0000, 2'b10);           // R9 invalid not trapped

    // half: every pattern narrow, strided wide
    for (int i = 0; i < 65536; i++)
      doOp(2'b11, 1'b0, 64'(i), 2'((i >> 3) ^ i));
    for (int i = 0; i < 65536; i += 5)
      doOp(2'b11, 1'b1, 64'(i), 2'(i >> 2));

    // single: every exponent, both signs and widths
    for (int e = 0; e < 256; e++)
      for (int k = 0; k < 8; k++)
        for (int sw = 0; sw < 4; sw++)
          doOp(2'b00, sw[0], {32'h0, sw[1], 8'(e), mantPat(k, 23)[22:0]}, 2'(e + k));

    // double: exponents around the integer range plus the ends
    for (int j = 0; j < 80; j++) begin
      int e;
      e = (j == 0) ? 0 : (j == 79) ? 2047 : 1023 - 5 + j;
      for (int k = 0; k < 8; k++)
        for (int sw = 0; sw < 4; sw++)
          doOp(2'b01, sw[0], {sw[1], 11'(e), mantPat(k, 52)[51:0]}, 2'(j + sw));
    end

    inValid = 1'b0;
    @(negedge clk);
    checks++;
    if (outValid !== 0) begin
      errors++;
      $display("FAIL R10 valid after idle: actual %b expected 0", outValid);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule